// File: doc/BRIEF.md
# Locked Priority Request Gating

This block lives inside a symmetric bus agent and decides, cycle by cycle, whether the agent may launch a new bus request. It watches four bus-level conditions: a request from the high-priority agent, a stall raised by any agent on a wired-OR line, a bus initialization pulse, and the agent's own wish to run a locked (atomic) sequence. When a pending local request is allowed out, the block raises a one-cycle grant.

Permission is recomputed only on every second clock edge, the edges on which the wired-OR stall line is defined. A priority request normally stops new issue. A locked sequence that has already started is the exception: it may keep issuing under a priority request, and the block drives the lock indication for the whole sequence. This keeps the sequence atomic, because the priority agent waits for the lock to fall before it takes the bus. The block also keeps the agent's rotating arbitration ID. When observation is enabled, a bus initialization pulse returns every state element, the ID included, to its reset value.

The reset is asynchronous and active low. It is expected to be released synchronously to `clk` by logic upstream of this block.

Top module: `bus_issue_gate`

## Requirements
- R1: While `rst_n` is low, `issue_grant`, `may_issue`, `lock_drive` and `sample_slot` are 0 and `rot_id` is 0.
- R2: `sample_slot` is 0 in the first cycle after reset or after an observed bus init, then toggles every cycle. `may_issue` can change only at a rising edge that closes a cycle in which `sample_slot` was 1, or at an observed bus init.
- R3: `issue_grant` is 1 in the cycle after a rising edge at which `local_req` and `may_issue` were 1 and `issue_grant` was 0. It is never high two cycles in a row.
- R4: When `stall_in` is 1 at a sampling edge, `may_issue` is 0 after that edge. When `stall_in` is 0 and no other condition blocks, `may_issue` is 1 after that edge.
- R5: When `prio_req` is 1 at a sampling edge, `may_issue` becomes 0, unless a locked sequence is in progress and `lock_req` is still 1.
- R6: `lock_drive` rises with the grant of a request made while `lock_req` is 1. It stays 1 while `lock_req` stays 1, and falls at the first edge at which `lock_req` is 0. A locked sequence cannot start while `may_issue` is 0.
- R7: `rot_id` advances by one, modulo `NUM_AGENTS`, at each edge at which `owner_move` is 1, and wraps from `NUM_AGENTS-1` to 0.
- R8: When `binit_in` and `binit_obs_en` are both 1 at an edge, every output returns to its reset value after that edge. When `binit_obs_en` is 0, `binit_in` has no effect.
- R9: A stall sampled during a locked sequence still removes permission, so the sequence cannot issue, while `lock_drive` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_req | input | 1 | Local agent has a request waiting to go out |
| lock_req | input | 1 | Local agent wants its requests to form one locked sequence |
| prio_req | input | 1 | Priority agent is requesting the bus |
| stall_in | input | 1 | Wired-OR stall line for new requests |
| binit_in | input | 1 | Bus initialization pulse |
| binit_obs_en | input | 1 | Configuration bit: act on bus initialization |
| owner_move | input | 1 | Symmetric ownership passes to another agent this cycle |
| issue_grant | output | 1 | One-cycle pulse: the pending request goes out |
| may_issue | output | 1 | Registered issue permission |
| lock_drive | output | 1 | Lock indication held for the local locked sequence |
| sample_slot | output | 1 | High in cycles whose closing edge samples the stall line |
| rot_id | output | $clog2(NUM_AGENTS) | Rotating arbitration ID |

## Verification
The vectors stop the stall line between sampling edges, to show that a design sampling it every cycle would drop or regain permission one cycle early. They raise a priority request partway through a locked sequence, where a design without the lock exception would break atomicity. They also raise one just after the sequence ends, where a design that kept the exception alive one cycle too long would grant under the priority agent. The ID is stepped through its wrap, and a bus init pulse is given once with observation disabled and once enabled. A design that ignored the enable, or left the lock or slot phase behind after an init, would show a wrong output on the next compare. A stall raised during a locked sequence must block issue while the lock stays driven.

// File: rtl/bus_issue_gate_pkg.sv
package bus_issue_gate_pkg;
  // Phase of the two-cycle stall sampling rhythm.
  typedef enum logic {
    SLOT_OPEN   = 1'b0,
    SLOT_SAMPLE = 1'b1
  } slot_e;
endpackage

// File: rtl/big_slot_timer.sv
module big_slot_timer
  import bus_issue_gate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  output slot_e slot_q
);
  slot_e slot_n;

  always_comb begin
    if (clr) slot_n = SLOT_OPEN;
    else     slot_n = (slot_q == SLOT_OPEN) ? SLOT_SAMPLE : SLOT_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SLOT_OPEN;
    else        slot_q <= slot_n;
  end
endmodule

// File: rtl/big_lock_track.sv
module big_lock_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fire,
  input  logic lock_req,
  output logic seq_n,
  output logic seq_q
);
  // A sequence opens with a granted locked request and lives while lock_req stays high.
  always_comb begin
    if (clr) seq_n = 1'b0;
    else     seq_n = lock_req & (fire | seq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= 1'b0;
    else        seq_q <= seq_n;
  end
endmodule

// File: rtl/big_perm_reg.sv
module big_perm_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sample_en,
  input  logic stall_in,
  input  logic prio_req,
  input  logic seq_live,
  output logic perm_q
);
  logic perm_n;
  logic perm_en;

  assign perm_en = clr | sample_en;

  always_comb begin
    if (clr) perm_n = 1'b0;
    else     perm_n = ~stall_in & (~prio_req | seq_live);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       perm_q <= 1'b0;
    else if (perm_en) perm_q <= perm_n;
  end
endmodule

// File: rtl/big_rot_id.sv
module big_rot_id #(
  parameter int NUM_AGENTS = 4,
  localparam int ID_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  output logic [ID_W-1:0] id_q
);
  localparam logic [ID_W-1:0] ID_LAST = ID_W'(NUM_AGENTS - 1);

  logic [ID_W-1:0] id_n;
  logic            id_en;

  assign id_en = clr | step;

  always_comb begin
    if (clr)                 id_n = '0;
    else if (id_q == ID_LAST) id_n = '0;
    else                     id_n = id_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (id_en) id_q <= id_n;
  end
endmodule

// File: rtl/bus_issue_gate.sv
module bus_issue_gate
  import bus_issue_gate_pkg::*;
#(
  parameter int NUM_AGENTS = 4,
  localparam int ID_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            local_req,
  input  logic            lock_req,
  input  logic            prio_req,
  input  logic            stall_in,
  input  logic            binit_in,
  input  logic            binit_obs_en,
  input  logic            owner_move,
  output logic            issue_grant,
  output logic            may_issue,
  output logic            lock_drive,
  output logic            sample_slot,
  output logic [ID_W-1:0] rot_id
);
  slot_e slot_q;
  logic  binit_hit;
  logic  fire;
  logic  seq_n;
  logic  seq_q;
  logic  grant_n;
  logic  grant_q;
  logic  perm_q;

  assign binit_hit = binit_in & binit_obs_en;
  assign fire      = local_req & perm_q & ~grant_q;

  big_slot_timer u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (binit_hit),
    .slot_q (slot_q)
  );

  big_lock_track u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (binit_hit),
    .fire     (fire),
    .lock_req (lock_req),
    .seq_n    (seq_n),
    .seq_q    (seq_q)
  );

  big_perm_reg u_perm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (binit_hit),
    .sample_en (slot_q == SLOT_SAMPLE),
    .stall_in  (stall_in),
    .prio_req  (prio_req),
    .seq_live  (seq_n),
    .perm_q    (perm_q)
  );

  big_rot_id #(.NUM_AGENTS(NUM_AGENTS)) u_id (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (binit_hit),
    .step  (owner_move),
    .id_q  (rot_id)
  );

  always_comb begin
    grant_n = fire & ~binit_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= 1'b0;
    else        grant_q <= grant_n;
  end

  assign issue_grant = grant_q;
  assign may_issue   = perm_q;
  assign lock_drive  = seq_q;
  assign sample_slot = (slot_q == SLOT_SAMPLE);
endmodule

// File: rtl/bus_issue_gate_chk.sv
module bus_issue_gate_chk #(
  parameter int NUM_AGENTS = 4,
  localparam int ID_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            local_req,
  input logic            lock_req,
  input logic            prio_req,
  input logic            stall_in,
  input logic            binit_in,
  input logic            binit_obs_en,
  input logic            owner_move,
  input logic            issue_grant,
  input logic            may_issue,
  input logic            lock_drive,
  input logic            sample_slot,
  input logic [ID_W-1:0] rot_id
);
  logic            hit;
  logic [ID_W-1:0] id_succ;

  assign hit     = binit_in & binit_obs_en;
  assign id_succ = (rot_id == ID_W'(NUM_AGENTS - 1)) ? '0 : rot_id + 1'b1;

  assert_perm_on_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(may_issue) |-> ($past(sample_slot) || $past(hit)));

  assert_slot_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (sample_slot != $past(sample_slot)));

  assert_grant_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_grant |=> !issue_grant);

  assert_grant_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_grant |-> $past(local_req && may_issue));

  assert_stall_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_slot && stall_in) |=> !may_issue);

  assert_prio_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_slot && prio_req && !lock_req) |=> !may_issue);

  assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_req |=> !lock_drive);

  assert_id_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rot_id <= ID_W'(NUM_AGENTS - 1));

  assert_id_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_move && !hit) |=> (rot_id == $past(id_succ)));

  assert_binit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!issue_grant && !may_issue && !lock_drive && !sample_slot && rot_id == '0));
endmodule

bind bus_issue_gate bus_issue_gate_chk #(.NUM_AGENTS(NUM_AGENTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .local_req    (local_req),
  .lock_req     (lock_req),
  .prio_req     (prio_req),
  .stall_in     (stall_in),
  .binit_in     (binit_in),
  .binit_obs_en (binit_obs_en),
  .owner_move   (owner_move),
  .issue_grant  (issue_grant),
  .may_issue    (may_issue),
  .lock_drive   (lock_drive),
  .sample_slot  (sample_slot),
  .rot_id       (rot_id)
);

// File: tb/bus_issue_gate_bench.sv
module bus_issue_gate_bench;
  localparam int N_AG   = 4;
  localparam int IDW    = 2;
  localparam int N_VEC  = 23;

  typedef struct packed {
    logic           stall;
    logic           prio;
    logic           lreq;
    logic           req;
    logic           move;
    logic           binit;
    logic           obs;
    logic           e_grant;
    logic           e_perm;
    logic           e_lock;
    logic [IDW-1:0] e_id;
    logic           e_slot;
  } vec_t;

  // stall prio lreq req move binit obs | grant perm lock id slot
  localparam vec_t VECS [N_VEC] = '{
    '{0,0,0,1,0,0,0, 0,0,0,2'd0,1}, // 0 no sample yet: R2
    '{0,0,0,1,0,0,0, 0,1,0,2'd0,0}, // 1 first sample opens permission: R4
    '{0,0,0,1,0,0,0, 1,1,0,2'd0,1}, // 2 grant: R3
    '{1,0,0,1,0,0,0, 0,0,0,2'd0,0}, // 3 grant drops, stall sampled: R3 R4
    '{0,0,0,1,0,0,0, 0,0,0,2'd0,1}, // 4 stall gone but not sampled: R2
    '{0,1,0,0,0,0,0, 0,0,0,2'd0,0}, // 5 priority request: R5
    '{0,0,0,0,1,0,0, 0,0,0,2'd1,1}, // 6 id step: R7
    '{0,0,0,0,1,0,0, 0,1,0,2'd2,0}, // 7
    '{0,0,1,1,1,0,0, 1,1,1,2'd3,1}, // 8 locked grant starts sequence: R6
    '{0,1,1,1,1,0,0, 0,1,1,2'd0,0}, // 9 priority held off, id wraps: R5 R7
    '{0,1,1,1,0,0,0, 1,1,1,2'd0,1}, // 10 locked issue under priority: R5
    '{0,1,0,0,0,0,0, 0,0,0,2'd0,0}, // 11 sequence ends, priority wins: R5 R6
    '{0,1,1,1,0,0,0, 0,0,0,2'd0,1}, // 12 no new lock without permission: R6
    '{0,0,0,0,1,1,0, 0,1,0,2'd1,0}, // 13 init ignored when disabled: R8
    '{0,0,0,1,1,1,1, 0,0,0,2'd0,0}, // 14 init observed: R8
    '{0,0,0,1,0,0,0, 0,0,0,2'd0,1}, // 15 slot restarted: R2 R8
    '{0,0,0,1,0,0,0, 0,1,0,2'd0,0}, // 16
    '{0,0,0,1,0,0,0, 1,1,0,2'd0,1}, // 17
    '{0,0,1,0,0,0,0, 0,1,0,2'd0,0}, // 18
    '{0,0,1,1,0,0,0, 1,1,1,2'd0,1}, // 19 lock again: R6
    '{1,1,1,1,0,0,0, 0,0,1,2'd0,0}, // 20 stall inside lock: R9
    '{0,1,1,1,0,0,0, 0,0,1,2'd0,1}, // 21 still blocked, lock held: R9
    '{0,0,1,0,0,1,1, 0,0,0,2'd0,0}  // 22 init clears lock: R8
  };

  logic           clk;
  logic           rst_n;
  logic           local_req, lock_req, prio_req, stall_in;
  logic           binit_in, binit_obs_en, owner_move;
  logic           issue_grant, may_issue, lock_drive, sample_slot;
  logic [IDW-1:0] rot_id;

  int n_cmp;
  int n_bad;
  bit done;

  bus_issue_gate #(.NUM_AGENTS(N_AG)) u_bus_issue_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .local_req    (local_req),
    .lock_req     (lock_req),
    .prio_req     (prio_req),
    .stall_in     (stall_in),
    .binit_in     (binit_in),
    .binit_obs_en (binit_obs_en),
    .owner_move   (owner_move),
    .issue_grant  (issue_grant),
    .may_issue    (may_issue),
    .lock_drive   (lock_drive),
    .sample_slot  (sample_slot),
    .rot_id       (rot_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp, input int row);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s row %0d: actual %0d expected %0d", tag, row, act, exp);
    end
  endtask

  task automatic check_all_zero(input int row);
    check("R1 issue_grant", int'(issue_grant), 0, row);
    check("R1 may_issue",   int'(may_issue),   0, row);
    check("R1 lock_drive",  int'(lock_drive),  0, row);
    check("R1 sample_slot", int'(sample_slot), 0, row);
    check("R1 rot_id",      int'(rot_id),      0, row);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    {local_req, lock_req, prio_req, stall_in, binit_in, binit_obs_en, owner_move} = '0;
    repeat (3) @(negedge clk);
    check_all_zero(-1);                       // R1 during reset
    rst_n = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      stall_in     = VECS[i].stall;
      prio_req     = VECS[i].prio;
      lock_req     = VECS[i].lreq;
      local_req    = VECS[i].req;
      owner_move   = VECS[i].move;
      binit_in     = VECS[i].binit;
      binit_obs_en = VECS[i].obs;
      @(posedge clk);
      @(negedge clk);
      check("R3 issue_grant", int'(issue_grant), int'(VECS[i].e_grant), i);
      check("R4 may_issue",   int'(may_issue),   int'(VECS[i].e_perm),  i);
      check("R6 lock_drive",  int'(lock_drive),  int'(VECS[i].e_lock),  i);
      check("R7 rot_id",      int'(rot_id),      int'(VECS[i].e_id),    i);
      check("R2 sample_slot", int'(sample_slot), int'(VECS[i].e_slot),  i);
    end

    // Directed: build non-zero state, then reset asynchronously (R1).
    {stall_in, prio_req, binit_in, binit_obs_en} = '0;
    lock_req   = 1'b1;
    local_req  = 1'b1;
    owner_move = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 rot_id before reset", int'(rot_id), 0, 100);   // four steps wrap to 0
    check("R6 lock_drive before reset", int'(lock_drive), 1, 100);
    owner_move = 1'b0;
    #3 rst_n = 1'b0;
    #2;
    check_all_zero(101);
    @(negedge clk);
    rst_n = 1'b1;
    summary();
  end
endmodule